// File: doc/BRIEF.md
# Floating-Point Stage Reservation Checker

This block sits at the issue point of a floating-point unit whose internal stages are shared between operation types. There are seven stages: unpack, operand shift, mantissa add, round, multiplier first stage, multiplier second stage and exception test. Each operation class has a fixed pattern that says which stages it uses in each cycle after it starts. The block holds a window of future stage bookings, one seven-bit mask per slot. It grants a request only when none of the new pattern's stage bits land on a slot where that stage is already booked. On a grant, it merges the pattern into the window.

Slot 0 of the window is the next stage-cycle the unit will consume. An advance strobe retires slot 0 and moves every other slot one step closer. An empty mask enters at the far end. The collision test and the merge are both made against the window as it will be after the shift in the same clock edge. This means a request that arrives together with an advance is judged against the slots that will actually line up with it. Grant and stall are combinational from the current window and the inputs.

Top module: `fpres_checker`

## Requirements
- R1: After reset the window is empty, so the first request of any defined class is granted.
- R2: Stage bits are unpack=0, shift=1, add=2, round=3, mul1=4, mul2=5, exception=6. Class code 0 (add/subtract) books {unpack}, {shift,add}, {add,round}, {round,shift} in pattern slots 0 to 3.
- R3: Class code 1 (multiply) books {unpack}, {exception,mul1}, {mul1}, {mul1}, {mul1}, {mul2}, {mul2,add}, {round} in slots 0 to 7.
- R4: Class codes 2 (negate) and 3 (absolute value) book {unpack}, then {shift}.
- R5: Class code 4 (compare) books {unpack}, {add}, {round}.
- R6: When any pattern bit meets a booked bit at the same slot, stall_o is high, grant_o is low and the window is left unchanged.
- R7: With valid_i low, grant_o and stall_o are low and nothing is booked.
- R8: Class codes 5 to 7 are refused: grant_o and stall_o stay low and nothing is booked.
- R9: Each advance moves every slot down by one and clears the last slot. Without an advance and without a grant, the window holds.
- R10: When a request and an advance occur in the same cycle, the collision test and the merge use the already-shifted window.
- R11: grant_o and stall_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue request |
| op_class_i | input | 3 | Operation class code |
| advance_i | input | 1 | Shift the window by one slot |
| grant_o | output | 1 | Request accepted and pattern booked |
| stall_o | output | 1 | Request refused because of a stage collision |

## Verification
The bench builds the block with DEPTH of 8, the smallest window that holds a full multiply pattern. At this depth a multiply occupies every slot, and the empty mask entering the last slot after a shift is checked on each later request. For every ordered pair of class codes (all eight codes), the bench issues the first code, applies 0 to 8 advances, and then issues the second code both with and without a same-cycle advance. This covers every relative offset between two patterns, including full drain. A long pseudo-random run then mixes requests, advances and idle cycles, so that several bookings overlap at once. Every expected value comes from a slot-mask model kept in the bench.

// File: rtl/fpres_pkg.sv
package fpres_pkg;
  localparam int unsigned NSTAGE  = 7;
  localparam int unsigned PAT_LEN = 8;

  typedef logic [NSTAGE-1:0] stage_mask_t;
  typedef stage_mask_t [PAT_LEN-1:0] pattern_t;

  localparam stage_mask_t SM_UNPACK = 7'b000_0001;
  localparam stage_mask_t SM_SHIFT  = 7'b000_0010;
  localparam stage_mask_t SM_ADD    = 7'b000_0100;
  localparam stage_mask_t SM_ROUND  = 7'b000_1000;
  localparam stage_mask_t SM_MUL1   = 7'b001_0000;
  localparam stage_mask_t SM_MUL2   = 7'b010_0000;
  localparam stage_mask_t SM_EXC    = 7'b100_0000;

  typedef enum logic [2:0] {
    OPC_ADDSUB = 3'd0,
    OPC_MUL    = 3'd1,
    OPC_NEG    = 3'd2,
    OPC_ABS    = 3'd3,
    OPC_CMP    = 3'd4
  } op_class_e;
endpackage

// File: rtl/fpres_pattern.sv
module fpres_pattern
  import fpres_pkg::*;
(
  input  logic [2:0] op_class_i,
  output pattern_t   pat_o,
  output logic       known_o
);
  always_comb begin
    pat_o   = '0;
    known_o = 1'b1;
    unique case (op_class_i)
      OPC_ADDSUB: begin
        pat_o[0] = SM_UNPACK;
        pat_o[1] = SM_SHIFT | SM_ADD;
        pat_o[2] = SM_ADD | SM_ROUND;
        pat_o[3] = SM_ROUND | SM_SHIFT;
      end
      OPC_MUL: begin
        pat_o[0] = SM_UNPACK;
        pat_o[1] = SM_EXC | SM_MUL1;
        pat_o[2] = SM_MUL1;
        pat_o[3] = SM_MUL1;
        pat_o[4] = SM_MUL1;
        pat_o[5] = SM_MUL2;
        pat_o[6] = SM_MUL2 | SM_ADD;
        pat_o[7] = SM_ROUND;
      end
      OPC_NEG, OPC_ABS: begin
        pat_o[0] = SM_UNPACK;
        pat_o[1] = SM_SHIFT;
      end
      OPC_CMP: begin
        pat_o[0] = SM_UNPACK;
        pat_o[1] = SM_ADD;
        pat_o[2] = SM_ROUND;
      end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpres_window.sv
module fpres_window
  import fpres_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    advance_i,
  input  logic                    book_i,
  input  pattern_t                pat_i,
  output stage_mask_t [DEPTH-1:0] view_o
);
  stage_mask_t [DEPTH-1:0] win_q, win_d;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    stage_mask_t nxt_slot, add_slot;
    if (k == DEPTH - 1) begin : g_last
      assign nxt_slot = advance_i ? '0 : win_q[k];
    end else begin : g_mid
      assign nxt_slot = advance_i ? win_q[k+1] : win_q[k];
    end
    if (k < PAT_LEN) begin : g_pat
      assign add_slot = book_i ? pat_i[k] : '0;
    end else begin : g_nopat
      assign add_slot = '0;
    end
    assign view_o[k] = nxt_slot;
    assign win_d[k]  = nxt_slot | add_slot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !book_i) |=> $stable(win_q));
  a_r9_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !book_i) |=> (win_q[0] == $past(win_q[1])));
  a_r9_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !book_i) |=> (win_q[DEPTH-1] == '0));
  a_r2_book_unpack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    book_i |=> win_q[0][0]);
endmodule

// File: rtl/fpres_collide.sv
module fpres_collide
  import fpres_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  stage_mask_t [DEPTH-1:0] view_i,
  input  pattern_t                pat_i,
  output logic                    hit_o
);
  localparam int unsigned NCMP = (DEPTH < PAT_LEN) ? DEPTH : PAT_LEN;

  logic [NCMP-1:0] slot_hit;
  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign slot_hit[k] = |(view_i[k] & pat_i[k]);
  end
  assign hit_o = |slot_hit;
endmodule

// File: rtl/fpres_checker.sv
module fpres_checker
  import fpres_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] op_class_i,
  input  logic       advance_i,
  output logic       grant_o,
  output logic       stall_o
);
  pattern_t                pat;
  logic                    known, hit;
  stage_mask_t [DEPTH-1:0] view;

  fpres_pattern i_pattern (
    .op_class_i(op_class_i),
    .pat_o     (pat),
    .known_o   (known)
  );

  fpres_collide #(.DEPTH(DEPTH)) i_collide (
    .view_i(view),
    .pat_i (pat),
    .hit_o (hit)
  );

  fpres_window #(.DEPTH(DEPTH)) i_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(advance_i),
    .book_i   (grant_o),
    .pat_i    (pat),
    .view_o   (view)
  );

  assign grant_o = valid_i & known & ~hit;
  assign stall_o = valid_i & known & hit;

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!grant_o && !stall_o));
  a_r8_unknown_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_i > 3'd4) |-> (!grant_o && !stall_o));
endmodule

// File: tb/test_fpres_checker.sv
module test_fpres_checker;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] cls = 3'd0;
  logic       adv = 1'b0;
  logic       grant, stall;

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] mw [DEPTH];

  always #5 clk = ~clk;

  fpres_checker #(.DEPTH(DEPTH)) i_fpres_checker (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_class_i(cls),
    .advance_i(adv), .grant_o(grant), .stall_o(stall)
  );

  // bit 0 unpack, 1 shift, 2 add, 3 round, 4 mul1, 5 mul2, 6 exception
  function automatic logic [6:0] pat_of(input logic [2:0] c, input int k);
    logic [6:0] r = '0;
    case (c)
      3'd0: case (k) 0: r = 7'h01; 1: r = 7'h06; 2: r = 7'h0C; 3: r = 7'h0A; default: ; endcase
      3'd1: case (k) 0: r = 7'h01; 1: r = 7'h50; 2,3,4: r = 7'h10; 5: r = 7'h20;
                     6: r = 7'h24; 7: r = 7'h08; default: ; endcase
      3'd2, 3'd3: case (k) 0: r = 7'h01; 1: r = 7'h02; default: ; endcase
      3'd4: case (k) 0: r = 7'h01; 1: r = 7'h04; 2: r = 7'h08; default: ; endcase
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < DEPTH; k++) mw[k] = '0;
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic a);
    logic [6:0] sh [DEPTH];
    logic col, def, eg, es;
    string tag;
    @(negedge clk);
    valid = v; cls = c; adv = a;
    for (int k = 0; k < DEPTH; k++) sh[k] = a ? ((k == DEPTH-1) ? 7'h00 : mw[k+1]) : mw[k];
    col = 1'b0;
    for (int k = 0; k < DEPTH; k++) col |= |(sh[k] & pat_of(c, k));
    def = (c < 3'd5);
    eg = v & def & ~col;
    es = v & def & col;
    if (!v) tag = "R7";
    else if (!def) tag = "R8";
    else if (col) tag = "R6";
    else if (a) tag = "R10";
    else if (c == 3'd0) tag = "R2";
    else if (c == 3'd1) tag = "R3";
    else if (c == 3'd4) tag = "R5";
    else tag = "R4";
    #1;
    check(grant, eg, tag, "grant");
    check(stall, es, tag, "stall");
    if (grant && stall) check(1'b1, 1'b0, "R11", "grant and stall together");
    for (int k = 0; k < DEPTH; k++) mw[k] = sh[k] | (eg ? pat_of(c, k) : 7'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 1'b0; adv = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: every defined class granted from an empty window
    for (int c = 0; c < 5; c++) begin
      do_reset();
      #1;
      check(stall, 1'b0, "R1", "stall after reset");
      step(1'b1, 3'(c), 1'b0);
      check(grant, 1'b1, "R1", "first grant after reset");
    end
    // R9: add then three advances: a second add fits, fewer advances collide
    for (int d = 0; d < 4; d++) begin
      do_reset();
      step(1'b1, 3'd0, 1'b0);
      for (int i = 0; i < d; i++) step(1'b0, 3'd0, 1'b1);
      #1;
      step(1'b1, 3'd0, 1'b0);
      check(grant, (d == 3), "R9", "add after add offset");
    end
    // pair sweep over all codes and offsets, with and without same-cycle advance
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int d = 0; d <= DEPTH; d++)
          for (int s = 0; s < 2; s++) begin
            do_reset();
            step(1'b1, 3'(a), 1'b0);
            for (int i = 0; i < d; i++) step(1'b0, 3'd0, 1'b1);
            step(1'b1, 3'(b), s[0]);
            step(1'b0, 3'd0, 1'b0);
            step(1'b1, 3'(b), 1'b0);
          end
    // mixed pseudo-random traffic
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[7], lfsr[3:1], lfsr[4] & lfsr[9]);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule